// File: doc/BRIEF.md
# Wakeup-and-Select Instruction Queue

This block holds renamed instructions between the rename stage and the register-file read stage. Each slot stores an operation code, a destination tag and two source tags, and each source tag has a ready flag. Every cycle, two wakeup channels are compared against every stored source tag that is still waiting. The external channel carries the result tag of any instruction that has completed. The loopback channel carries the destination tag of the instruction this queue issued one cycle earlier, which models a single-cycle execution unit. A tag match sets that operand's ready flag.

The queue is kept compact. Valid slots always occupy indices 0 to count-1, in program order, so the oldest instruction sits at index 0. When an instruction issues, every younger slot moves down by one position. Because of this, selection is a plain fixed-priority encoder that picks the lowest-indexed slot whose sources are both ready. At most one instruction issues per cycle. Its opcode, destination tag and both source tags appear on the issue port, and a later stage uses the source tags to read the register file.

New instructions enter at the first free slot after that cycle's compaction. A full flag stops new entries. A flush input empties the queue in one cycle.

Top module: `wakeup_issue_queue`

## Requirements
- R1: After reset the queue is empty: `issueValid`, `full` and `bcastValid` are all 0.
- R2: A slot can issue only when it is valid and both of its stored source-ready flags are set. When a slot issues, `issueValid` is 1 in that same cycle and `issueOp`, `issueDst`, `issueSrcA` and `issueSrcB` show that slot's stored fields.
- R3: When several slots are eligible, the one with the lowest index issues, which is the oldest. Instructions with ready operands therefore issue in program order.
- R4: A waiting source becomes ready when its tag equals `wbTag` while `wbValid` is 1, or equals `bcastTag` while `bcastValid` is 1. The flag is set at that clock edge, so the earliest the woken slot can issue is the next cycle.
- R5: If a source tag presented at dispatch matches either wakeup channel in the dispatch cycle, that source is stored as ready, even when its dispatch ready input is 0.
- R6: After an issue from slot k, slots above k each move down one index in the same edge, keeping their order. An accepted dispatch is written at index count, minus one if an issue happens in the same cycle.
- R7: `full` is 1 exactly when all DEPTH slots are valid. A dispatch presented while `full` is 1 is dropped, even if an issue happens in the same cycle.
- R8: While `flush` is 1, `issueValid` is 0 and any dispatch is dropped. After that edge the queue is empty.
- R9: `bcastValid` and `bcastTag` equal the previous cycle's `issueValid` and `issueDst`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Empties the queue at the next edge and suppresses issue and dispatch this cycle |
| dispValid | input | 1 | A new instruction is presented for dispatch |
| dispOp | input | OP_W | Operation code of the new instruction |
| dispDst | input | TAG_W | Destination tag of the new instruction |
| dispSrcA | input | TAG_W | First source tag |
| dispSrcARdy | input | 1 | First source is already available |
| dispSrcB | input | TAG_W | Second source tag |
| dispSrcBRdy | input | 1 | Second source is already available |
| wbValid | input | 1 | External completion tag is valid |
| wbTag | input | TAG_W | External completion tag |
| full | output | 1 | All slots are occupied and dispatch is refused |
| issueValid | output | 1 | An instruction issues this cycle |
| issueOp | output | OP_W | Operation code of the issuing instruction |
| issueDst | output | TAG_W | Destination tag of the issuing instruction |
| issueSrcA | output | TAG_W | First source tag, used for the register-file read |
| issueSrcB | output | TAG_W | Second source tag, used for the register-file read |
| bcastValid | output | 1 | Loopback wakeup tag is valid |
| bcastTag | output | TAG_W | Destination tag issued in the previous cycle |

## Verification
Faults inside the queue show up at the issue port, usually within one or two cycles.

- A lost or spurious ready flag changes the cycle in which a dependent instruction first issues. A dependent that is woken too late misses its slot, and one that is woken too early jumps ahead.
- A faulty shift duplicates or loses an instruction. The effect is visible as an out-of-order `issueDst` sequence, or as a tag that issues twice or never.
- A wrong slot count moves `full` by a cycle, or lets a dropped dispatch appear on the issue port later.

The stimulus therefore checks the exact cycle of every issue, and drains the queue completely after the full and flush cases so that a leftover instruction cannot go unnoticed.

// File: rtl/iq_pkg.sv
package iq_pkg;

  // Strobes the control half sends to the slot array each cycle.
  typedef struct packed {
    logic issueEn;   // one slot leaves this cycle
    logic dispEn;    // a new instruction is written this cycle
    logic flushEn;   // drop every slot at the edge
  } iq_strobe_t;

endpackage

// File: rtl/iq_ctrl.sv
module iq_ctrl
  import iq_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          flush,
  input  logic                          dispValid,
  input  logic [DEPTH-1:0]              eligVec,
  output iq_strobe_t                    stb,
  output logic [$clog2(DEPTH)-1:0]      issueIdx,
  output logic [$clog2(DEPTH)-1:0]      dispIdx,
  output logic                          full
);

  localparam int IDX_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [CNT_W-1:0] cntQ;
  logic [CNT_W-1:0] cntNext;
  logic             anyElig;
  logic [IDX_W-1:0] selIdx;

  // Fixed-priority pick: the lowest index is the oldest slot.
  always_comb begin
    selIdx  = '0;
    anyElig = 1'b0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (eligVec[i]) begin
        selIdx  = IDX_W'(i);
        anyElig = 1'b1;
      end
    end
  end

  assign full = (cntQ == CNT_W'(DEPTH));

  always_comb begin
    stb.flushEn = flush;
    stb.issueEn = anyElig && !flush;
    stb.dispEn  = dispValid && !full && !flush;
  end

  assign issueIdx = selIdx;
  // First free slot after this cycle's compaction.
  assign dispIdx  = IDX_W'(cntQ - CNT_W'(stb.issueEn));

  always_comb begin
    if (flush) cntNext = '0;
    else       cntNext = cntQ + CNT_W'(stb.dispEn) - CNT_W'(stb.issueEn);
  end

  always_ff @(posedge clk) begin
    if (!rstN) cntQ <= '0;
    else       cntQ <= cntNext;
  end

  assert_full_blocks_dispatch_R7: assert property (@(posedge clk) disable iff (!rstN)
    full |-> !stb.dispEn);

  assert_count_bound_R7: assert property (@(posedge clk) disable iff (!rstN)
    cntQ <= CNT_W'(DEPTH));

  assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> (cntQ == '0));

  assert_oldest_first_R3: assert property (@(posedge clk) disable iff (!rstN)
    stb.issueEn |-> ((eligVec & ((DEPTH'(1) << issueIdx) - DEPTH'(1))) == '0));

endmodule

// File: rtl/iq_datapath.sv
module iq_datapath
  import iq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int TAG_W = 7,
  parameter int OP_W  = 6
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  iq_strobe_t                    stb,
  input  logic [$clog2(DEPTH)-1:0]      issueIdx,
  input  logic [$clog2(DEPTH)-1:0]      dispIdx,
  input  logic [OP_W-1:0]               dispOp,
  input  logic [TAG_W-1:0]              dispDst,
  input  logic [TAG_W-1:0]              dispSrcA,
  input  logic                          dispSrcARdy,
  input  logic [TAG_W-1:0]              dispSrcB,
  input  logic                          dispSrcBRdy,
  input  logic                          wbValid,
  input  logic [TAG_W-1:0]              wbTag,
  output logic [DEPTH-1:0]              eligVec,
  output logic [OP_W-1:0]               issueOp,
  output logic [TAG_W-1:0]              issueDst,
  output logic [TAG_W-1:0]              issueSrcA,
  output logic [TAG_W-1:0]              issueSrcB,
  output logic                          lbValid,
  output logic [TAG_W-1:0]              lbTag
);

  localparam int IDX_W = $clog2(DEPTH);

  typedef struct packed {
    logic             valid;
    logic [OP_W-1:0]  op;
    logic [TAG_W-1:0] dst;
    logic [TAG_W-1:0] srcA;
    logic             rdyA;
    logic [TAG_W-1:0] srcB;
    logic             rdyB;
  } slot_t;

  slot_t      slotQ  [DEPTH];  // stored state
  slot_t      slotW  [DEPTH];  // stored state after this cycle's wakeup
  slot_t      newSlot;
  logic [DEPTH-1:0] validVec;

  // Tag match against both wakeup channels.
  function automatic logic tagHit(input logic [TAG_W-1:0] t,
                                  input logic v0, input logic [TAG_W-1:0] t0,
                                  input logic v1, input logic [TAG_W-1:0] t1);
    return (v0 && (t0 == t)) || (v1 && (t1 == t));
  endfunction

  // Incoming instruction, with same-cycle wakeup folded in.
  always_comb begin
    newSlot.valid = 1'b1;
    newSlot.op    = dispOp;
    newSlot.dst   = dispDst;
    newSlot.srcA  = dispSrcA;
    newSlot.srcB  = dispSrcB;
    newSlot.rdyA  = dispSrcARdy || tagHit(dispSrcA, wbValid, wbTag, lbValid, lbTag);
    newSlot.rdyB  = dispSrcBRdy || tagHit(dispSrcB, wbValid, wbTag, lbValid, lbTag);
  end

  for (genvar g = 0; g < DEPTH; g++) begin : gSlot
    slot_t reg_q;
    slot_t upper;
    slot_t nxt;
    logic  takeUpper;

    assign slotQ[g]    = reg_q;
    assign validVec[g] = reg_q.valid;
    // Selection uses the stored flags only, so a wakeup this cycle
    // can lead to an issue no earlier than the next cycle.
    assign eligVec[g]  = reg_q.valid && reg_q.rdyA && reg_q.rdyB;

    // Wakeup comparators, one pair for each source of this slot.
    always_comb begin
      slotW[g]      = reg_q;
      slotW[g].rdyA = reg_q.rdyA || tagHit(reg_q.srcA, wbValid, wbTag, lbValid, lbTag);
      slotW[g].rdyB = reg_q.rdyB || tagHit(reg_q.srcB, wbValid, wbTag, lbValid, lbTag);
    end

    if (g < DEPTH - 1) begin : gHasUpper
      assign upper = slotW[g+1];
    end else begin : gTopSlot
      assign upper = '0;
    end

    assign takeUpper = stb.issueEn && (IDX_W'(g) >= issueIdx);

    always_comb begin
      nxt = takeUpper ? upper : slotW[g];
      if (stb.dispEn && (dispIdx == IDX_W'(g))) nxt = newSlot;
      if (stb.flushEn) nxt.valid = 1'b0;
    end

    always_ff @(posedge clk) begin
      if (!rstN) reg_q <= '0;
      else       reg_q <= nxt;
    end
  end

  assign issueOp   = slotQ[issueIdx].op;
  assign issueDst  = slotQ[issueIdx].dst;
  assign issueSrcA = slotQ[issueIdx].srcA;
  assign issueSrcB = slotQ[issueIdx].srcB;

  // Single-cycle execution model: the issued destination returns as a wakeup tag.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      lbValid <= 1'b0;
      lbTag   <= '0;
    end else begin
      lbValid <= stb.issueEn;
      lbTag   <= slotQ[issueIdx].dst;
    end
  end

  assert_compact_slots_R6: assert property (@(posedge clk) disable iff (!rstN)
    ((validVec & (validVec + DEPTH'(1))) == '0));

  assert_issue_only_ready_R2: assert property (@(posedge clk) disable iff (!rstN)
    stb.issueEn |-> (slotQ[issueIdx].valid && slotQ[issueIdx].rdyA && slotQ[issueIdx].rdyB));

  assert_dispatch_in_free_slot_R6: assert property (@(posedge clk) disable iff (!rstN)
    stb.dispEn |-> (!validVec[dispIdx] || (stb.issueEn && (dispIdx >= issueIdx))));

  assert_loopback_follows_issue_R9: assert property (@(posedge clk) disable iff (!rstN)
    stb.issueEn |=> (lbValid && (lbTag == $past(slotQ[issueIdx].dst))));

endmodule

// File: rtl/wakeup_issue_queue.sv
module wakeup_issue_queue
  import iq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int TAG_W = 7,
  parameter int OP_W  = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flush,
  input  logic             dispValid,
  input  logic [OP_W-1:0]  dispOp,
  input  logic [TAG_W-1:0] dispDst,
  input  logic [TAG_W-1:0] dispSrcA,
  input  logic             dispSrcARdy,
  input  logic [TAG_W-1:0] dispSrcB,
  input  logic             dispSrcBRdy,
  input  logic             wbValid,
  input  logic [TAG_W-1:0] wbTag,
  output logic             full,
  output logic             issueValid,
  output logic [OP_W-1:0]  issueOp,
  output logic [TAG_W-1:0] issueDst,
  output logic [TAG_W-1:0] issueSrcA,
  output logic [TAG_W-1:0] issueSrcB,
  output logic             bcastValid,
  output logic [TAG_W-1:0] bcastTag
);

  localparam int IDX_W = $clog2(DEPTH);

  iq_strobe_t       stb;
  logic [IDX_W-1:0] issueIdx;
  logic [IDX_W-1:0] dispIdx;
  logic [DEPTH-1:0] eligVec;

  iq_ctrl #(.DEPTH(DEPTH)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .flush     (flush),
    .dispValid (dispValid),
    .eligVec   (eligVec),
    .stb       (stb),
    .issueIdx  (issueIdx),
    .dispIdx   (dispIdx),
    .full      (full)
  );

  iq_datapath #(.DEPTH(DEPTH), .TAG_W(TAG_W), .OP_W(OP_W)) uData (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .issueIdx    (issueIdx),
    .dispIdx     (dispIdx),
    .dispOp      (dispOp),
    .dispDst     (dispDst),
    .dispSrcA    (dispSrcA),
    .dispSrcARdy (dispSrcARdy),
    .dispSrcB    (dispSrcB),
    .dispSrcBRdy (dispSrcBRdy),
    .wbValid     (wbValid),
    .wbTag       (wbTag),
    .eligVec     (eligVec),
    .issueOp     (issueOp),
    .issueDst    (issueDst),
    .issueSrcA   (issueSrcA),
    .issueSrcB   (issueSrcB),
    .lbValid     (bcastValid),
    .lbTag       (bcastTag)
  );

  assign issueValid = stb.issueEn;

  assert_no_issue_in_flush_R8: assert property (@(posedge clk) disable iff (!rstN)
    flush |-> !issueValid);

endmodule

// File: tb/tb_wakeup_issue_queue.sv
module tb_wakeup_issue_queue;

  localparam int DEPTH = 4;
  localparam int TAG_W = 7;
  localparam int OP_W  = 4;

  logic             clk = 1'b0;
  logic             rstN;
  logic             flush;
  logic             dispValid;
  logic [OP_W-1:0]  dispOp;
  logic [TAG_W-1:0] dispDst, dispSrcA, dispSrcB;
  logic             dispSrcARdy, dispSrcBRdy;
  logic             wbValid;
  logic [TAG_W-1:0] wbTag;
  logic             full, issueValid, bcastValid;
  logic [OP_W-1:0]  issueOp;
  logic [TAG_W-1:0] issueDst, issueSrcA, issueSrcB, bcastTag;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;  // 50 MHz

  wakeup_issue_queue #(.DEPTH(DEPTH), .TAG_W(TAG_W), .OP_W(OP_W)) dut (
    .clk(clk), .rstN(rstN), .flush(flush),
    .dispValid(dispValid), .dispOp(dispOp), .dispDst(dispDst),
    .dispSrcA(dispSrcA), .dispSrcARdy(dispSrcARdy),
    .dispSrcB(dispSrcB), .dispSrcBRdy(dispSrcBRdy),
    .wbValid(wbValid), .wbTag(wbTag),
    .full(full), .issueValid(issueValid), .issueOp(issueOp),
    .issueDst(issueDst), .issueSrcA(issueSrcA), .issueSrcB(issueSrcB),
    .bcastValid(bcastValid), .bcastTag(bcastTag)
  );

  typedef struct packed {
    logic       dv;
    logic [6:0] dst;
    logic [6:0] sa;
    logic       ra;
    logic [6:0] sb;
    logic       rb;
    logic       wv;
    logic [6:0] wt;
    logic       eiv;   // expected issueValid in this cycle
    logic [6:0] eid;   // expected issueDst
    logic       ef;    // expected full
    logic       ebv;   // expected bcastValid
    logic [6:0] ebt;   // expected bcastTag
  } vec_t;

  localparam int NV = 16;
  // Each row: dispatch inputs, external wakeup, and the outputs expected in that cycle.
  localparam vec_t VECS [NV] = '{
    '{1'b1, 7'd10, 7'd1,  1'b1, 7'd2,  1'b1, 1'b0, 7'd0,  1'b0, 7'd0,  1'b0, 1'b0, 7'd0 },
    '{1'b1, 7'd11, 7'd10, 1'b0, 7'd3,  1'b1, 1'b0, 7'd0,  1'b1, 7'd10, 1'b0, 1'b0, 7'd0 },
    '{1'b1, 7'd12, 7'd11, 1'b0, 7'd11, 1'b0, 1'b0, 7'd0,  1'b0, 7'd0,  1'b0, 1'b1, 7'd10},
    '{1'b1, 7'd13, 7'd20, 1'b0, 7'd5,  1'b1, 1'b1, 7'd20, 1'b1, 7'd11, 1'b0, 1'b0, 7'd0 },
    '{1'b0, 7'd0,  7'd0,  1'b0, 7'd0,  1'b0, 1'b0, 7'd0,  1'b1, 7'd13, 1'b0, 1'b1, 7'd11},
    '{1'b0, 7'd0,  7'd0,  1'b0, 7'd0,  1'b0, 1'b0, 7'd0,  1'b1, 7'd12, 1'b0, 1'b1, 7'd13},
    '{1'b1, 7'd20, 7'd40, 1'b0, 7'd6,  1'b1, 1'b0, 7'd0,  1'b0, 7'd0,  1'b0, 1'b1, 7'd12},
    '{1'b1, 7'd21, 7'd40, 1'b0, 7'd6,  1'b1, 1'b0, 7'd0,  1'b0, 7'd0,  1'b0, 1'b0, 7'd0 },
    '{1'b1, 7'd22, 7'd40, 1'b0, 7'd6,  1'b1, 1'b0, 7'd0,  1'b0, 7'd0,  1'b0, 1'b0, 7'd0 },
    '{1'b1, 7'd23, 7'd40, 1'b0, 7'd6,  1'b1, 1'b0, 7'd0,  1'b0, 7'd0,  1'b0, 1'b0, 7'd0 },
    '{1'b1, 7'd30, 7'd7,  1'b1, 7'd7,  1'b1, 1'b1, 7'd40, 1'b0, 7'd0,  1'b1, 1'b0, 7'd0 },
    '{1'b0, 7'd0,  7'd0,  1'b0, 7'd0,  1'b0, 1'b0, 7'd0,  1'b1, 7'd20, 1'b1, 1'b0, 7'd0 },
    '{1'b0, 7'd0,  7'd0,  1'b0, 7'd0,  1'b0, 1'b0, 7'd0,  1'b1, 7'd21, 1'b0, 1'b1, 7'd20},
    '{1'b0, 7'd0,  7'd0,  1'b0, 7'd0,  1'b0, 1'b0, 7'd0,  1'b1, 7'd22, 1'b0, 1'b1, 7'd21},
    '{1'b0, 7'd0,  7'd0,  1'b0, 7'd0,  1'b0, 1'b0, 7'd0,  1'b1, 7'd23, 1'b0, 1'b1, 7'd22},
    '{1'b0, 7'd0,  7'd0,  1'b0, 7'd0,  1'b0, 1'b0, 7'd0,  1'b0, 7'd0,  1'b0, 1'b1, 7'd23}
  };

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic idleInputs();
    flush = 1'b0; dispValid = 1'b0; dispOp = '0; dispDst = '0;
    dispSrcA = '0; dispSrcARdy = 1'b0; dispSrcB = '0; dispSrcBRdy = 1'b0;
    wbValid = 1'b0; wbTag = '0;
  endtask

  task automatic present(input logic dv, input logic [6:0] dst, input logic [6:0] sa,
                         input logic ra, input logic [6:0] sb, input logic rb);
    dispValid = dv; dispDst = dst; dispOp = dst[OP_W-1:0];
    dispSrcA = sa; dispSrcARdy = ra; dispSrcB = sb; dispSrcBRdy = rb;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (3000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    idleInputs();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #5;
    check("R1 issueValid after reset", issueValid, 0);
    check("R1 full after reset", full, 0);
    check("R1 bcastValid after reset", bcastValid, 0);

    // Table walk: wakeup, order, compaction, full and drain (R2 R3 R4 R5 R6 R7 R9).
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      idleInputs();
      present(VECS[i].dv, VECS[i].dst, VECS[i].sa, VECS[i].ra, VECS[i].sb, VECS[i].rb);
      wbValid = VECS[i].wv; wbTag = VECS[i].wt;
      #5;
      check($sformatf("R2 R3 R4 issueValid row %0d", i), issueValid, VECS[i].eiv);
      if (VECS[i].eiv) begin
        check($sformatf("R3 R6 issueDst row %0d", i), issueDst, VECS[i].eid);
        check($sformatf("R2 issueOp row %0d", i), issueOp, VECS[i].eid[OP_W-1:0]);
      end
      check($sformatf("R7 full row %0d", i), full, VECS[i].ef);
      check($sformatf("R9 bcastValid row %0d", i), bcastValid, VECS[i].ebv);
      if (VECS[i].ebv) check($sformatf("R9 bcastTag row %0d", i), bcastTag, VECS[i].ebt);
    end

    // R8: flush while a ready slot is present, with a matching wakeup in the same cycle.
    @(negedge clk); idleInputs(); present(1'b1, 7'd60, 7'd70, 1'b0, 7'd8, 1'b1);
    @(negedge clk); idleInputs(); present(1'b1, 7'd62, 7'd9, 1'b1, 7'd9, 1'b1);
    #5 check("R2 waiting slot does not issue", issueValid, 0);
    @(negedge clk); idleInputs(); flush = 1'b1; wbValid = 1'b1; wbTag = 7'd70;
    present(1'b1, 7'd64, 7'd9, 1'b1, 7'd9, 1'b1);
    #5 check("R8 no issue during flush", issueValid, 0);
    @(negedge clk); idleInputs();
    #5;
    check("R8 empty after flush", issueValid, 0);
    check("R8 loopback quiet after flush", bcastValid, 0);
    check("R8 full clear after flush", full, 0);
    @(negedge clk); idleInputs();
    #5 check("R8 dropped dispatch absent", issueValid, 0);

    // R2 R6: dispatch after flush lands in slot 0 and issues with its source tags.
    @(negedge clk); idleInputs(); present(1'b1, 7'd63, 7'd33, 1'b1, 7'd44, 1'b1);
    @(negedge clk); idleInputs();
    #5;
    check("R2 issue after flush", issueValid, 1);
    check("R2 issueDst after flush", issueDst, 63);
    check("R2 issueSrcA", issueSrcA, 33);
    check("R2 issueSrcB", issueSrcB, 44);
    @(negedge clk); idleInputs();
    #5;
    check("R9 loopback tag", bcastTag, 63);
    check("R6 queue drained", issueValid, 0);

    summary();
    $finish;
  end

endmodule